// File: doc/BRIEF.md
# Chainable Synchronous Binary Up-Counter

This block is a binary up-counter built from 4-bit stages that all share one clock and advance on its rising edge. Each stage has three controls:

- **Clear.** An active-low clear takes effect at once, without waiting for the clock.
- **Load.** An active-low synchronous load copies a preset word into the count.
- **Enables.** There are two count enables. Both must be high for the stage to advance.

Only one of the two enables also qualifies the stage's terminal-count output. That lets one stage's carry serve as the next stage's gating enable.

The top module chains a parameterised number of stages. The first stage receives the external enables. The second enable is broadcast to every stage. Each later stage takes its gating enable from the terminal-count output of the stage below it. The whole chain therefore behaves as one wide synchronous counter. Its terminal-count output can feed a further chain.

Top module: `sync_count_chain`

## Requirements
- R1: While clear_n is low, q is all zeros and tc is low, whatever the clock, load_n, preset and enables do. Both outputs react within the same clock phase, without waiting for an edge.
- R2: With clear_n high and load_n low at a rising edge, q takes the value of preset, whatever the levels of enable_p and enable_t.
- R3: With clear_n and load_n high and both enables high at a rising edge, q increases by one. The increment applies to q read as one unsigned STAGES*4-bit number, so a stage that is all ones carries into the stage above it on the same edge.
- R4: Counting from the all-ones value gives all zeros on the next enabled edge.
- R5: With load_n high and enable_p low, q keeps its value across rising edges, even when enable_t is high.
- R6: With load_n high and enable_t low, q keeps its value across rising edges, even when enable_p is high.
- R7: tc is high exactly when enable_t is high and every bit of q is one. tc follows enable_t within the same clock phase, so a low enable_t forces tc low.
- R8: enable_p never changes tc. With q all ones and enable_t high, tc stays high for either level of enable_p.
- R9: The controls rank clear first, then load, then count, then hold. A low clear_n at an edge keeps q at zero even when load_n is low. A low load_n wins over both enables being high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_n | input | 1 | Asynchronous active-low clear of the whole count |
| load_n | input | 1 | Synchronous active-low load of preset |
| preset | input | STAGES*4 | Value copied into q on a load edge |
| enable_p | input | 1 | Count enable broadcast to all stages; does not affect tc |
| enable_t | input | 1 | Count enable of the lowest stage; also gates tc |
| q | output | STAGES*4 | Current count; stage 0 holds the low nibble |
| tc | output | 1 | Terminal count: enable_t high and q all ones |

## Verification
The bound checker checks the following on every edge:

- the load, increment, wrap and hold outcome of each edge, taken across the full chain width;
- the terminal-count decode against enable_t and q;
- the zero state while clear is held.

Some behaviour falls between clock edges, and only the bench's scenarios can show it. These are:

- clear arriving in mid-phase and acting at once;
- tc tracking enable_t toggles within one low clock phase;
- enable_p toggled at the all-ones value without moving tc.

The bench also sweeps the count across several stage carries and wraps. It compares every step with a plain integer model.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;

  localparam int unsigned NIBBLE = 4;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } mode_e;

  // load outranks counting; counting needs both enables
  function automatic mode_e pick_mode(input logic load_n,
                                      input logic en_p,
                                      input logic en_t);
    if (!load_n)            return MODE_LOAD;
    else if (en_p && en_t)  return MODE_COUNT;
    else                    return MODE_HOLD;
  endfunction

endpackage

// File: rtl/cnt_stage_next.sv
`timescale 1ns/1ps
module cnt_stage_next
  import cnt_pkg::*;
#(
  parameter int unsigned W = NIBBLE
) (
  input  mode_e          mode,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   preset,
  output logic [W-1:0]   nxt
);

  localparam logic [W-1:0] STEP = W'(1);

  always_comb begin
    unique case (mode)
      MODE_LOAD:  nxt = preset;
      MODE_COUNT: nxt = cur + STEP;
      default:    nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_carry.sv
`timescale 1ns/1ps
module cnt_carry #(
  parameter int unsigned W = 4
) (
  input  logic         en_t,
  input  logic [W-1:0] cur,
  output logic         tc
);

  assign tc = en_t & (&cur);

endmodule

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W = NIBBLE
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         tc
);

  mode_e        mode;
  logic         cnt_en;
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nxt;

  assign mode   = pick_mode(load_n, en_p, en_t);
  assign cnt_en = (mode != MODE_HOLD);

  cnt_stage_next #(.W(W)) u_next (
    .mode   (mode),
    .cur    (cnt_r),
    .preset (preset),
    .nxt    (cnt_nxt)
  );

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      cnt_r <= '0;
    end else if (cnt_en) begin
      cnt_r <= cnt_nxt;
    end
  end

  cnt_carry #(.W(W)) u_carry (
    .en_t (en_t),
    .cur  (cnt_r),
    .tc   (tc)
  );

  assign q = cnt_r;

endmodule

// File: rtl/sync_count_chain.sv
`timescale 1ns/1ps
module sync_count_chain #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned STAGE_W = cnt_pkg::NIBBLE
) (
  input  logic                        clk,
  input  logic                        clear_n,
  input  logic                        load_n,
  input  logic [STAGES*STAGE_W-1:0]   preset,
  input  logic                        enable_p,
  input  logic                        enable_t,
  output logic [STAGES*STAGE_W-1:0]   q,
  output logic                        tc
);

  localparam int unsigned TOTAL_W = STAGES * STAGE_W;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic en_t_in;
    logic tc_out;

    if (g == 0) begin : g_first
      assign en_t_in = enable_t;
    end else begin : g_link
      assign en_t_in = g_stage[g-1].tc_out;
    end

    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .preset  (preset[g*STAGE_W +: STAGE_W]),
      .en_p    (enable_p),
      .en_t    (en_t_in),
      .q       (q[g*STAGE_W +: STAGE_W]),
      .tc      (tc_out)
    );
  end

  assign tc = g_stage[STAGES-1].tc_out;

  initial begin
    if (TOTAL_W == 0) $error("sync_count_chain: zero width");
  end

endmodule

// File: rtl/sync_count_chain_chk.sv
`timescale 1ns/1ps
module sync_count_chain_chk #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned STAGE_W = 4
) (
  input logic                        clk,
  input logic                        clear_n,
  input logic                        load_n,
  input logic [STAGES*STAGE_W-1:0]   preset,
  input logic                        enable_p,
  input logic                        enable_t,
  input logic [STAGES*STAGE_W-1:0]   q,
  input logic                        tc
);

  localparam int unsigned TW = STAGES * STAGE_W;
  localparam logic [TW-1:0] ONE = TW'(1);

  always @(posedge clk) begin
    if (clear_n === 1'b0) begin
      AST_CLEAR_ZERO: assert (q == '0 && !tc) else $error("clear not holding zero"); // R1
    end
  end

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> q == $past(preset)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && enable_p && enable_t) |=> q == $past(q) + ONE); // R3

  AST_HOLD_P_LOW: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !enable_p) |=> $stable(q)); // R5

  AST_HOLD_T_LOW: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !enable_t) |=> $stable(q)); // R6

  AST_TC_DECODE: assert property (@(posedge clk) disable iff (!clear_n)
    tc == (enable_t && (&q))); // R7

  AST_TC_IGNORES_P: assert property (@(posedge clk) disable iff (!clear_n)
    (!enable_p && enable_t && (&q)) |-> tc); // R8

endmodule

bind sync_count_chain sync_count_chain_chk #(
  .STAGES  (STAGES),
  .STAGE_W (STAGE_W)
) u_chk (
  .clk      (clk),
  .clear_n  (clear_n),
  .load_n   (load_n),
  .preset   (preset),
  .enable_p (enable_p),
  .enable_t (enable_t),
  .q        (q),
  .tc       (tc)
);

// File: tb/sync_count_chain_bench.sv
`timescale 1ns/1ps
module sync_count_chain_bench;

  localparam int unsigned STAGES = 2;
  localparam int unsigned W      = STAGES * 4;

  logic         clk;
  logic         clear_n;
  logic         load_n;
  logic [W-1:0] preset;
  logic         enable_p;
  logic         enable_t;
  logic [W-1:0] q;
  logic         tc;

  int unsigned  n_total;
  int unsigned  n_fail;
  logic [W-1:0] model;

  sync_count_chain #(.STAGES(STAGES)) u_sync_count_chain (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .preset   (preset),
    .enable_p (enable_p),
    .enable_t (enable_t),
    .q        (q),
    .tc       (tc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one rising edge, then settle to the following low phase
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] v, input logic p, input logic t);
    load_n = 1'b0; preset = v; enable_p = p; enable_t = t;
    tick();
    model = v;
    load_n = 1'b1;
  endtask

  task automatic t_reset();
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset q", q, 0);
    chk("R1 reset tc", tc, 0);
    clear_n = 1'b1;
  endtask

  task automatic t_load_enables_low();
    do_load(8'hA5, 1'b0, 1'b0);
    chk("R2 load both low", q, 8'hA5);
    do_load(8'h3C, 1'b1, 1'b0);
    chk("R2 load t low", q, 8'h3C);
    do_load(8'h69, 1'b0, 1'b1);
    chk("R2 load p low", q, 8'h69);
  endtask

  task automatic t_count_sweep();
    do_load(8'h0F, 1'b0, 1'b0);
    enable_p = 1'b1; enable_t = 1'b1;
    tick();
    chk("R3 nibble carry", q, 8'h10);
    do_load(8'hF9, 1'b0, 1'b0);
    enable_p = 1'b1; enable_t = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic wrap;
      wrap  = (model == '1);
      model = model + 1'b1;
      tick();
      if (wrap) chk("R4 wrap", q, model);
      else      chk("R3 count", q, model);
    end
    enable_p = 1'b0; enable_t = 1'b0;
  endtask

  task automatic t_hold(input logic p, input logic t, input string tag);
    do_load(8'h37, 1'b0, 1'b0);
    enable_p = p; enable_t = t;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(tag, q, 8'h37);
    end
    enable_p = 1'b0; enable_t = 1'b0;
  endtask

  task automatic t_tc();
    do_load(8'hFE, 1'b0, 1'b0);
    enable_t = 1'b1;
    #0.2;
    chk("R7 tc low below max", tc, 0);
    enable_t = 1'b0;
    do_load(8'hFF, 1'b0, 1'b0);
    chk("R7 tc low when t low", tc, 0);
    #0.3 enable_t = 1'b1;
    #0.2 chk("R7 tc follows t high", tc, 1);
    chk("R8 tc with p low", tc, 1);
    #0.2 enable_p = 1'b1;
    #0.2 chk("R8 tc with p high", tc, 1);
    #0.2 enable_p = 1'b0;
    #0.2 chk("R8 tc after p falls", tc, 1);
    #0.2 enable_t = 1'b0;
    #0.2 chk("R7 tc follows t low", tc, 0);
    tick();
    chk("R6 count held at max", q, 8'hFF);
  endtask

  task automatic t_clear_priority();
    do_load(8'hFF, 1'b0, 1'b0);
    enable_t = 1'b1;
    #0.2 chk("R7 tc before clear", tc, 1);
    #0.3 clear_n = 1'b0;
    #0.2;
    chk("R1 mid-phase clear q", q, 0);
    chk("R1 mid-phase clear tc", tc, 0);
    load_n = 1'b0; preset = 8'h55; enable_p = 1'b1;
    tick();
    chk("R9 clear over load", q, 0);
    clear_n = 1'b1;
    tick();
    chk("R9 load over count", q, 8'h55);
    load_n = 1'b1;
    tick();
    chk("R3 count after load", q, 8'h56);
    enable_p = 1'b0; enable_t = 1'b0;
  endtask

  initial begin
    n_total = 0; n_fail = 0; model = '0;
    clear_n = 1'b0; load_n = 1'b1; preset = '0;
    enable_p = 1'b0; enable_t = 1'b0;
    t_reset();
    t_load_enables_low();
    t_count_sweep();
    t_hold(1'b0, 1'b1, "R5 hold p low");
    t_hold(1'b1, 1'b0, "R6 hold t low");
    t_tc();
    t_clear_priority();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule